// File: doc/BRIEF.md
# Program/Erase Busy Status Responder

This block sits on the read path of a nonvolatile memory macro and answers reads while an internally timed program or erase operation runs. A one-cycle start request begins the operation. The block holds the word loaded with a program request, or an all-ones word for an erase. It then keeps a busy flag high for a fixed number of clock cycles, set by a parameter for each kind of operation.

While busy, the read word carries two completion signatures at once. Bit 7 is the inverse of bit 7 of the held word. Bit 6 changes value on each new read access. All other bits read zero. A read access begins when chip enable and output enable first become active together, as seen in the system clock domain. Dropping and raising either enable therefore starts another access. When the timer expires, reads pass the array data through unchanged, and bit 6 stops moving.

Software can poll either signature from the first cycle of the busy period. Array storage and command decoding are outside this block.

Top module: `busy_status_resp`

## Requirements
- R1: After reset, busy_o is 0 and rd_data_o equals array_data_i on every bit.
- R2: A program request (prog_start_i high at a clock edge while idle) raises busy_o from the next cycle, for exactly PROG_CYCLES cycles.
- R3: An erase request (erase_start_i high at a clock edge while idle) raises busy_o for exactly ERASE_CYCLES cycles.
- R4: Start requests arriving while busy_o is high are ignored. The running duration and the held word are unchanged.
- R5: While busy after a program request, rd_data_o bit 7 equals the inverse of bit 7 of load_data_i captured with that request.
- R6: While busy after an erase request, rd_data_o bit 7 reads 0, because the held word is all ones.
- R7: While busy, rd_data_o bit 6 inverts once after every clock edge at which (chip_en_i AND out_en_i) is high and was low at the previous edge. At any other edge it holds its value.
- R8: A new access may be formed by cycling only out_en_i with chip_en_i held high, or by cycling only chip_en_i with out_en_i held high.
- R9: While busy, every bit of rd_data_o other than bits 7 and 6 reads 0.
- R10: While idle, rd_data_o equals array_data_i on all bits. Accesses made while idle do not advance bit 6, which is seen on the next busy period.
- R11: If program and erase requests arrive together while idle, the program request wins: its duration and data are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_start_i | input | 1 | One-cycle program request |
| erase_start_i | input | 1 | One-cycle erase request |
| load_data_i | input | DATA_W | Word loaded with a program request |
| chip_en_i | input | 1 | Chip enable, active high |
| out_en_i | input | 1 | Output enable, active high |
| array_data_i | input | DATA_W | True array read data |
| rd_data_o | output | DATA_W | Read word with status substituted while busy |
| busy_o | output | 1 | Operation in progress |

## Verification
The bench measures the exact busy length for both kinds of operation. A timer that is off by one would stretch or shorten busy by a cycle. It tracks bit 6 against a model that advances only on access edges seen while busy. A design that toggled on every cycle with the enables active, or while idle, would break the alternation or the bit 6 value carried into the next busy period.

It fires start requests in the middle of busy periods. A design that accepted them would restart the timer or change the polarity of bit 7. It also sends program and erase requests in the same cycle, where the wrong priority shows up as an erase-length busy period and a bit 7 of zero.

// File: rtl/busy_resp_pkg.sv
package busy_resp_pkg;
  localparam int unsigned POLL_BIT   = 7;
  localparam int unsigned TOGGLE_BIT = 6;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_e;
endpackage

// File: rtl/op_timer.sv
module op_timer #(
  parameter int unsigned PROG_CYCLES  = 500,
  parameter int unsigned ERASE_CYCLES = 500000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     prog_start_i,
  input  logic                     erase_start_i,
  output logic                     accept_o,
  output busy_resp_pkg::op_kind_e  accept_kind_o,
  output logic                     busy_o
);
  import busy_resp_pkg::*;

  localparam int unsigned MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign accept_o      = !busy_q && (prog_start_i || erase_start_i);
  // program wins when both arrive together
  assign accept_kind_o = prog_start_i ? OP_PROG : OP_ERASE;
  assign busy_o        = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (accept_o) begin
      cnt_q  <= (accept_kind_o == OP_PROG) ? PROG_LOAD : ERASE_LOAD;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  a_r2_start_sets_busy : assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_q);
  a_r4_no_restart : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
  a_r3_fall_at_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(cnt_q) == '0));
endmodule

// File: rtl/access_detect.sv
module access_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chip_en_i,
  input  logic out_en_i,
  output logic new_access_o
);
  logic act, act_q;

  assign act          = chip_en_i && out_en_i;
  assign new_access_o = act && !act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act;
  end

  a_r8_single_edge : assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_access_o |=> !new_access_o);
endmodule

// File: rtl/status_merge.sv
module status_merge #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     accept_i,
  input  busy_resp_pkg::op_kind_e  accept_kind_i,
  input  logic [DATA_W-1:0]        load_data_i,
  input  logic                     busy_i,
  input  logic                     new_access_i,
  input  logic [DATA_W-1:0]        array_data_i,
  output logic [DATA_W-1:0]        rd_data_o
);
  import busy_resp_pkg::*;

  logic [DATA_W-1:0] held_q;
  logic              tgl_q;
  logic [DATA_W-1:0] status_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '1;
    end else if (accept_i) begin
      held_q <= (accept_kind_i == OP_PROG) ? load_data_i : '1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    tgl_q <= 1'b0;
    else if (new_access_i && busy_i) tgl_q <= !tgl_q;
  end

  always_comb begin
    status_word             = '0;
    status_word[POLL_BIT]   = !held_q[POLL_BIT];
    status_word[TOGGLE_BIT] = tgl_q;
  end

  assign rd_data_o = busy_i ? status_word : array_data_i;

  a_r4_held_stable : assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(held_q));
  a_r7_toggle_only_on_access : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(new_access_i && busy_i) |=> $stable(tgl_q));
  a_r9_quiet_bits : assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> ($countones(rd_data_o) <= 2));
endmodule

// File: rtl/busy_status_resp.sv
module busy_status_resp #(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned PROG_CYCLES  = 500,
  parameter int unsigned ERASE_CYCLES = 500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_start_i,
  input  logic              erase_start_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              chip_en_i,
  input  logic              out_en_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o
);
  import busy_resp_pkg::*;

  logic     accept;
  op_kind_e accept_kind;
  logic     new_access;

  op_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prog_start_i (prog_start_i),
    .erase_start_i(erase_start_i),
    .accept_o     (accept),
    .accept_kind_o(accept_kind),
    .busy_o       (busy_o)
  );

  access_detect u_detect (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chip_en_i   (chip_en_i),
    .out_en_i    (out_en_i),
    .new_access_o(new_access)
  );

  status_merge #(.DATA_W(DATA_W)) u_merge (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .accept_kind_i(accept_kind),
    .load_data_i  (load_data_i),
    .busy_i       (busy_o),
    .new_access_i (new_access),
    .array_data_i (array_data_i),
    .rd_data_o    (rd_data_o)
  );

  a_r10_idle_passthrough : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (rd_data_o == array_data_i));
endmodule

// File: tb/busy_status_resp_tb_top.sv
module busy_status_resp_tb_top;
  localparam int DW = 16;
  localparam int PC = 12;
  localparam int EC = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sp = 1'b0, se = 1'b0, ce = 1'b0, oe = 1'b0;
  logic [DW-1:0] ld = '0, arr = '0;
  logic [DW-1:0] rd;
  logic          busy;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] held_m = '1;
  logic exp_tgl = 1'b0, tgl_known = 1'b0, acc_prev = 1'b0;
  bit   op_active = 0;
  int   op_len = 0, exp_len = 0;
  string cur_req = "R2";

  always #4 clk = !clk;

  busy_status_resp #(.DATA_W(DW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .prog_start_i(sp), .erase_start_i(se),
    .load_data_i(ld), .chip_en_i(ce), .out_en_i(oe), .array_data_i(arr),
    .rd_data_o(rd), .busy_o(busy));

  function automatic logic [DW-1:0] status_exp(logic [DW-1:0] h, logic t);
    logic [DW-1:0] w = '0;
    w[7] = !h[7];
    w[6] = t;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // check at current negedge, then drive, then advance to the next negedge
  task automatic cyc(input logic c, input logic o, input logic p, input logic e, input logic [DW-1:0] d);
    logic acc, rise;
    if (busy) begin
      op_len++;
      chk(rd[15:8] == 8'h00 && rd[5:0] == 6'h00, "R9", rd, status_exp(held_m, rd[6]));
      chk(rd[7] == !held_m[7], cur_req, rd, status_exp(held_m, rd[6]));
      if (tgl_known) chk(rd[6] == exp_tgl, "R7", rd, status_exp(held_m, exp_tgl));
      else begin exp_tgl = rd[6]; tgl_known = 1'b1; end
    end else begin
      if (op_active) begin
        chk(op_len == exp_len, (exp_len == PC) ? "R2" : "R3", DW'(op_len), DW'(exp_len));
        op_active = 0;
      end
      chk(rd == arr, "R10", rd, arr);
    end
    acc  = c & o;
    rise = acc & !acc_prev;
    if (rise && busy) exp_tgl = !exp_tgl;
    acc_prev = acc;
    if (!busy && (p || e)) begin
      held_m    = p ? d : '1;
      exp_len   = p ? PC : EC;
      cur_req   = p ? ((p && e) ? "R11" : "R5") : "R6";
      op_active = 1;
      op_len    = 0;
    end
    ce = c; oe = o; sp = p; se = e; ld = d;
    arr = DW'($urandom);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    int g = 0;
    while ((busy || op_active) && g < 200) begin
      cyc(1'b0, 1'b0, 1'b0, 1'b0, '0);
      g++;
    end
  endtask

  initial begin
    #(8 * 60000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1", DW'(busy), '0);
    chk(rd == arr, "R1", rd, arr);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", DW'(busy), '0);
    cyc(1, 1, 0, 0, '0);
    cyc(0, 0, 0, 0, '0);

    // R2/R5 program, bit7 set; R8 cycle only out_en, then only chip_en
    cyc(0, 0, 1, 0, 16'h0080);
    for (int i = 0; i < 4; i++) cyc(1, i[0], 0, 0, '0);
    for (int i = 0; i < 4; i++) cyc(i[0], 1, 0, 0, '0);
    wait_idle();
    // R10: idle accesses must not move bit 6
    for (int i = 0; i < 6; i++) cyc(i[0], 1, 0, 0, '0);
    cyc(0, 0, 0, 0, '0);

    // R3/R6 erase, with R4 restart attempts mid-way
    cyc(0, 0, 0, 1, 16'h1234);
    for (int i = 0; i < 10; i++) cyc(1, i[0], 0, 0, '0);
    cyc(0, 0, 1, 0, 16'h0000);
    cyc(0, 0, 0, 1, '0);
    wait_idle();

    // R11 simultaneous requests, program bit7 clear
    cyc(0, 0, 1, 1, 16'hff7f);
    for (int i = 0; i < 3; i++) cyc(i[0], i[0], 0, 0, '0);
    wait_idle();

    // random traffic
    for (int n = 0; n < 1500; n++) begin
      logic c, o, p, e;
      c = ($urandom_range(0, 3) != 0);
      o = $urandom_range(0, 1);
      p = ($urandom_range(0, 15) == 0);
      e = ($urandom_range(0, 63) == 0);
      cyc(c, o, p, e, DW'($urandom));
    end
    wait_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule